// File: doc/BRIEF.md
# Comparator Change-Flag Unit

This unit watches a small group of digital comparator results and raises a sticky interrupt flag when any of them no longer agrees with the value captured the last time software accessed the comparator status register. It does not compare against the previous clock cycle. The flag keeps being re-armed for as long as the disagreement lasts, so software must access the status register before clearing the flag.

Each raw comparator result first passes through a two-stage synchronizer. It then passes through its own polarity-invert control, and the result is both presented in the status register and compared with the snapshot. A read or a write of the status register reloads the snapshot. A write also loads the invert controls. The flag is exposed to a flag write port, so software can clear it or force it set. The interrupt request is the flag gated by three enables: the comparator's own enable, the peripheral enable and the global enable.

Top module: `cmp_chg_flag`

## Requirements
- R1: While reset is asserted and on its release, the flag, the interrupt request and every status bit read as 0.
- R2: Status register layout: comparator 1 is in bit 7 and comparator 0 is in bit 6, each equal to its raw input XOR its invert control. Bits 5 (comparator 1) and 4 (comparator 0) return the invert controls. Bits 3:0 read 0. A raw input change shows in the status bits after two rising clock edges.
- R3: When a status bit differs from its snapshot in a cycle with no register access, the flag is 1 after the next rising edge.
- R4: A read strobe loads the snapshot with the current status bits, which ends the mismatch.
- R5: A register write loads the invert controls from write-data bits 5:4. It also loads the snapshot with the values that those new controls produce, so an invert change alone does not set the flag.
- R6: While a mismatch persists, writing 0 to the flag leaves it at 1.
- R7: With no mismatch, a flag write of 0 clears the flag and a flag write of 1 sets it.
- R8: When a hardware set and a software clear land in the same cycle, the flag ends at 1.
- R9: The interrupt request is 1 only when the flag and all three enables are 1. The flag sets regardless of the enables.
- R10: If a read strobe falls in the first cycle that a new comparator value is visible in the status bits, that change does not set the flag.
- R11: After reset is released with comparator inputs at 1, no flag is raised while the synchronizer fills. The snapshot follows the status bits for SYNC_STAGES+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_raw_i | input | NUM_CMP | Raw comparator results |
| creg_rd_i | input | 1 | Status register read strobe |
| creg_wr_i | input | 1 | Status register write strobe |
| creg_wdata_i | input | 8 | Status register write data |
| creg_rdata_o | output | 8 | Status register read data |
| flag_wr_i | input | 1 | Flag write strobe |
| flag_wdata_i | input | 1 | Flag write value |
| cmp_ie_i | input | 1 | Comparator interrupt enable |
| periph_ie_i | input | 1 | Peripheral interrupt enable |
| global_ie_i | input | 1 | Global interrupt enable |
| cmp_flag_o | output | 1 | Change flag |
| irq_o | output | 1 | Gated interrupt request |

## Verification
The bench builds the unit with the defaults NUM_CMP = 2 and SYNC_STAGES = 2. With these values the exact two-edge input latency, and the three-cycle settle window after reset, can be timed to the cycle. These values also make the same-cycle read race reachable with a single strobe placed between the second and third edges after an input change. Both comparators can be toggled together or alone, so single-bit and two-bit mismatches are both covered.

// File: rtl/cmpflag_pkg.sv
// Package: shared widths and types for the comparator change-flag unit.
// Assumes an 8-bit register bus.
package cmpflag_pkg;
    localparam int REG_W = 8;
    typedef logic [REG_W-1:0] reg_t;
endpackage

// File: rtl/cmp_sync.sv
// Multi-stage synchronizer for a vector of comparator results.
// Assumes each bit is an independent level signal.
// The output lags the input by STAGES rising edges and clears on reset.
module cmp_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // first capture flop
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= '0;
                else        stg[g] <= d_i;
            end
        end else begin : g_next
            // later stages shift the captured value along
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= '0;
                else        stg[g] <= stg[g-1];
            end
        end
    end

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/cmp_snap.sv
// Polarity, snapshot and mismatch logic.
// Holds the invert controls and the access snapshot, and raises a set request
// when a polarity-adjusted result disagrees with its snapshot in a cycle
// without a snapshot load. For SETTLE+1 cycles after reset the snapshot
// tracks the live values, so the synchronizer fill raises no request.
module cmp_snap #(
    parameter int N      = 2,
    parameter int SETTLE = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sync_i,
    input  logic         rd_i,
    input  logic         wr_i,
    input  logic [N-1:0] inv_wdata_i,
    output logic [N-1:0] cur_o,
    output logic [N-1:0] inv_o,
    output logic [N-1:0] snap_o,
    output logic         load_o,
    output logic         settle_o,
    output logic         set_req_o
);
    localparam int CW = $clog2(SETTLE + 2);
    localparam logic [CW-1:0] LAST = CW'(SETTLE + 1);

    logic [N-1:0]  inv_q, inv_d, snap_q, snap_d;
    logic [CW-1:0] cnt_q;

    assign inv_d    = wr_i ? inv_wdata_i : inv_q;
    assign snap_d   = sync_i ^ inv_d;
    assign cur_o    = sync_i ^ inv_q;
    assign settle_o = (cnt_q != LAST);
    assign load_o   = rd_i | wr_i | settle_o;
    assign set_req_o = (|(cur_o ^ snap_q)) & ~load_o;
    assign inv_o    = inv_q;
    assign snap_o   = snap_q;

    // invert control register, loaded by a register write
    always_ff @(posedge clk) begin
        if (!rst_n) inv_q <= '0;
        else        inv_q <= inv_d;
    end

    // snapshot latch, reloaded on any access or while settling
    always_ff @(posedge clk) begin
        if (!rst_n)      snap_q <= '0;
        else if (load_o) snap_q <= snap_d;
    end

    // post-reset settle counter, saturates at LAST
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt_q <= '0;
        else if (settle_o) cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/cmp_flag_ctl.sv
// Sticky change flag and interrupt gating.
// A hardware set request takes priority over a software write in the same
// cycle. The request leaves only when all three enables are high.
module cmp_flag_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req_i,
    input  logic flag_wr_i,
    input  logic flag_wdata_i,
    input  logic cmp_ie_i,
    input  logic periph_ie_i,
    input  logic global_ie_i,
    output logic flag_o,
    output logic irq_o
);
    logic flag_q;

    // flag register: hardware set first, then software write, else hold
    always_ff @(posedge clk) begin
        if (!rst_n)         flag_q <= 1'b0;
        else if (set_req_i) flag_q <= 1'b1;
        else if (flag_wr_i) flag_q <= flag_wdata_i;
    end

    assign flag_o = flag_q;
    assign irq_o  = flag_q & cmp_ie_i & periph_ie_i & global_ie_i;
endmodule

// File: rtl/cmp_chg_flag.sv
// Top level of the comparator change-flag unit.
// Synchronizes the raw results, applies polarity and snapshot compare,
// and drives the sticky flag and the gated interrupt request.
// Assumes 2*NUM_CMP fits in the register width.
module cmp_chg_flag
    import cmpflag_pkg::*;
#(
    parameter int NUM_CMP     = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CMP-1:0] cmp_raw_i,
    input  logic               creg_rd_i,
    input  logic               creg_wr_i,
    input  logic [REG_W-1:0]   creg_wdata_i,
    output logic [REG_W-1:0]   creg_rdata_o,
    input  logic               flag_wr_i,
    input  logic               flag_wdata_i,
    input  logic               cmp_ie_i,
    input  logic               periph_ie_i,
    input  logic               global_ie_i,
    output logic               cmp_flag_o,
    output logic               irq_o
);
    localparam int OUT_HI = REG_W - 1;
    localparam int INV_HI = REG_W - 1 - NUM_CMP;

    logic [NUM_CMP-1:0] sync_w, cur_w, inv_w, snap_w;
    logic               load_w, settle_w, set_req_w;

    cmp_sync #(.W(NUM_CMP), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (cmp_raw_i),
        .q_o   (sync_w)
    );

    cmp_snap #(.N(NUM_CMP), .SETTLE(SYNC_STAGES)) u_snap (
        .clk         (clk),
        .rst_n       (rst_n),
        .sync_i      (sync_w),
        .rd_i        (creg_rd_i),
        .wr_i        (creg_wr_i),
        .inv_wdata_i (creg_wdata_i[INV_HI -: NUM_CMP]),
        .cur_o       (cur_w),
        .inv_o       (inv_w),
        .snap_o      (snap_w),
        .load_o      (load_w),
        .settle_o    (settle_w),
        .set_req_o   (set_req_w)
    );

    cmp_flag_ctl u_flag (
        .clk          (clk),
        .rst_n        (rst_n),
        .set_req_i    (set_req_w),
        .flag_wr_i    (flag_wr_i),
        .flag_wdata_i (flag_wdata_i),
        .cmp_ie_i     (cmp_ie_i),
        .periph_ie_i  (periph_ie_i),
        .global_ie_i  (global_ie_i),
        .flag_o       (cmp_flag_o),
        .irq_o        (irq_o)
    );

    // status register assembly: results on top, invert controls below
    always_comb begin
        creg_rdata_o = '0;
        creg_rdata_o[OUT_HI -: NUM_CMP] = cur_w;
        creg_rdata_o[INV_HI -: NUM_CMP] = inv_w;
    end
endmodule

// File: rtl/cmp_chg_flag_chk.sv
// Assertion checker for cmp_chg_flag, attached by bind.
// Observes the internal compare values next to the ports.
module cmp_chg_flag_chk #(
    parameter int N = 2
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] cur,
    input logic [N-1:0] snap,
    input logic         rd,
    input logic         wr,
    input logic         load,
    input logic         flag_wr,
    input logic         flag_wdata,
    input logic         flag,
    input logic         irq,
    input logic         gie
);
    // R3
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur != snap && !load) |=> flag);
    // R4
    snap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !wr) |=> (snap == $past(cur)));
    // R6
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && cur != snap && !load) |=> flag);
    // R7
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_wr && !flag_wdata && (cur == snap || load)) |=> !flag);
    // R9
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flag && gie));
endmodule

bind cmp_chg_flag cmp_chg_flag_chk #(.N(NUM_CMP)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cur        (cur_w),
    .snap       (snap_w),
    .rd         (creg_rd_i),
    .wr         (creg_wr_i),
    .load       (load_w),
    .flag_wr    (flag_wr_i),
    .flag_wdata (flag_wdata_i),
    .flag       (cmp_flag_o),
    .irq        (irq_o),
    .gie        (global_ie_i)
);

// File: tb/cmp_chg_flag_bench.sv
module cmp_chg_flag_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] raw = 2'b00;
    logic       rd = 1'b0, wr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       fwr = 1'b0, fwd = 1'b0;
    logic       cie = 1'b0, pie = 1'b0, gie = 1'b0;
    logic       flag, irq;
    int         n_chk = 0, n_fail = 0, cyc = 0;

    always #10 clk = ~clk;

    cmp_chg_flag u_cmp_chg_flag (
        .clk(clk), .rst_n(rst_n), .cmp_raw_i(raw),
        .creg_rd_i(rd), .creg_wr_i(wr), .creg_wdata_i(wdata),
        .creg_rdata_o(rdata), .flag_wr_i(fwr), .flag_wdata_i(fwd),
        .cmp_ie_i(cie), .periph_ie_i(pie), .global_ie_i(gie),
        .cmp_flag_o(flag), .irq_o(irq)
    );

    // table entries: {raw[1:0], expected flag}
    localparam logic [2:0] VEC [6] = '{3'b011, 3'b010, 3'b111,
                                       3'b101, 3'b100, 3'b001};

    task automatic chk(input bit ok, input string req,
                       input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 5000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 5000);
            finish_up();
        end
    end

    task automatic access_and_clear();
        rd = 1'b1;
        @(negedge clk) rd = 1'b0; fwr = 1'b1; fwd = 1'b0;
        @(negedge clk) fwr = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(flag == 1'b0 && irq == 1'b0, "R1 flag/irq in reset", {6'b0, flag, irq}, 8'h00);
        chk(rdata == 8'h00, "R1 status in reset", rdata, 8'h00);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(flag == 1'b0, "R1 flag after release", {7'b0, flag}, 8'h00);

        // table walk: R2 status, R3 set, R9 enables off, R4/R7 access and clear
        for (int i = 0; i < 6; i++) begin
            raw = VEC[i][2:1];
            repeat (3) @(negedge clk);
            chk(rdata == {VEC[i][2:1], 6'b0}, "R2 status bits", rdata, {VEC[i][2:1], 6'b0});
            chk(flag == VEC[i][0], "R3 flag on change", {7'b0, flag}, {7'b0, VEC[i][0]});
            chk(irq == 1'b0, "R9 irq blocked by enables", {7'b0, irq}, 8'h00);
            access_and_clear();
            chk(flag == 1'b0, "R4 R7 flag after read and clear", {7'b0, flag}, 8'h00);
        end

        // R5 invert write: snapshot follows, no flag
        wr = 1'b1; wdata = 8'h30;
        @(negedge clk) wr = 1'b0;
        @(negedge clk);
        chk(rdata == 8'hF0, "R5 inverted status", rdata, 8'hF0);
        @(negedge clk);
        chk(flag == 1'b0, "R5 no flag from invert", {7'b0, flag}, 8'h00);
        wr = 1'b1; wdata = 8'h00;
        @(negedge clk) wr = 1'b0;
        repeat (2) @(negedge clk);
        chk(rdata == 8'h00 && flag == 1'b0, "R5 restore invert", rdata, 8'h00);

        // R6 R8 clear during persistent mismatch
        raw = 2'b01;
        repeat (3) @(negedge clk);
        chk(flag == 1'b1, "R3 flag set", {7'b0, flag}, 8'h01);
        fwr = 1'b1; fwd = 1'b0;
        @(negedge clk) fwr = 1'b0;
        chk(flag == 1'b1, "R6 R8 clear loses to mismatch", {7'b0, flag}, 8'h01);
        access_and_clear();
        chk(flag == 1'b0, "R4 clear after read", {7'b0, flag}, 8'h00);

        // R7 software set, R9 gating
        fwr = 1'b1; fwd = 1'b1;
        @(negedge clk) fwr = 1'b0;
        chk(flag == 1'b1, "R7 software set", {7'b0, flag}, 8'h01);
        cie = 1'b1; pie = 1'b1; gie = 1'b1;
        #1 chk(irq == 1'b1, "R9 irq all enables", {7'b0, irq}, 8'h01);
        gie = 1'b0;
        #1 chk(irq == 1'b0 && flag == 1'b1, "R9 irq global off", {6'b0, flag, irq}, 8'h02);
        cie = 1'b0; pie = 1'b0;
        fwr = 1'b1; fwd = 1'b0;
        @(negedge clk) fwr = 1'b0;
        chk(flag == 1'b0, "R7 software clear", {7'b0, flag}, 8'h00);

        // R10 read in first visible cycle of a change
        raw = 2'b11;
        @(posedge clk); @(posedge clk);
        @(negedge clk) rd = 1'b1;
        @(negedge clk) rd = 1'b0;
        chk(flag == 1'b0, "R10 race missed flag", {7'b0, flag}, 8'h00);
        @(negedge clk);
        chk(flag == 1'b0 && rdata == 8'hC0, "R10 still clear", rdata, 8'hC0);

        // R11 reset with inputs high
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(rdata == 8'h00 && flag == 1'b0, "R1 second reset", rdata, 8'h00);
        rst_n = 1'b1;
        repeat (8) @(negedge clk);
        chk(flag == 1'b0, "R11 no false flag", {7'b0, flag}, 8'h00);
        chk(rdata == 8'hC0, "R11 status settled", rdata, 8'hC0);
        finish_up();
    end
endmodule